// File: doc/BRIEF.md
# Two-Digit Decimal Up/Down Counter with Button-Controlled Direction

This block keeps a decimal count from 00 to 99 and moves it by one step on each cycle where an external count-enable pulse is high. The direction of counting is a stored state. Each clean press of a pushbutton reverses it. The raw button line is first brought into the clock domain and then filtered, so contact bounce and short spikes do not flip the direction.

A synchronous load request copies a starting value from an eight-bit switch bank into the two digits and also restores the up direction. The switch byte is read as two BCD nibbles, with the tens digit in the upper nibble. A nibble above nine is clamped to nine. Each digit is also decoded to an active-low seven-segment pattern for direct display.

Dividing the clock down to a rate a person can see is left to the surrounding logic, which supplies the enable pulse.

Top module: `bcd_dial_counter`

## Requirements
- R1: While `load_i` is high at a clock edge, the digits take `sw_i[3:0]` (ones) and `sw_i[7:4]` (tens) on that edge, and each nibble above 9 becomes 9.
- R2: A load sets the direction to up (`dir_up_o` = 1). A load takes priority over a step or a toggle on the same edge.
- R3: With `tick_i` low and no load, the digits keep their value.
- R4: Counting up, each tick adds one in decimal. The ones digit goes from 9 to 0 and carries into the tens digit, and 99 goes to 00.
- R5: Counting down, each tick subtracts one in decimal. The ones digit goes from 0 to 9 and borrows from the tens digit, and 00 goes to 99.
- R6: A button level (high = pressed) that stays stable for `DEBOUNCE_CYCLES` clocks after two synchroniser stages counts as a press. Each press toggles the direction exactly once. A pulse shorter than that window has no effect.
- R7: Each segment output is active low, with bit 0 = a through bit 6 = g. Bit 7 is the decimal point and is always 1 (off).
- R8: Both digits are always within 0..9.
- R9: When a toggle and a tick fall on the same edge, that step uses the old direction, and the new direction applies from the next step on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| load_i | input | 1 | Synchronous reset and load request, active high |
| sw_i | input | 8 | Start value: tens in [7:4], ones in [3:0] |
| btn_i | input | 1 | Raw pushbutton, high when pressed |
| tick_i | input | 1 | Count-enable pulse |
| ones_o | output | 4 | Ones digit, BCD |
| tens_o | output | 4 | Tens digit, BCD |
| seg_ones_n_o | output | 8 | Active-low segments for the ones digit |
| seg_tens_n_o | output | 8 | Active-low segments for the tens digit |
| dir_up_o | output | 1 | 1 when counting up |

## Verification
A wrong carry or borrow shows on the very next tick at a 9/0 boundary, as a tens digit that does not move or a non-BCD value. A corrupted direction shows on the first tick after it, as a step the wrong way. A fault in the debounce counter only shows after a full filter window, as a missing toggle, a double toggle, or a glitch that gets through. The directed tests therefore hold the button for a known number of cycles and check the direction and the digits on every tick around each press.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int BCD_W  = 4;
    localparam int DIGITS = 2;
    localparam int SEG_W  = 8;
    localparam int SW_W   = BCD_W * DIGITS;

    typedef logic [BCD_W-1:0] bcd_t;

    // Returns {wrap, next}: one decimal step of a single digit.
    function automatic logic [BCD_W:0] bcd_step(input bcd_t v, input logic up);
        logic [BCD_W:0] r;
        if (up) begin
            if (v >= bcd_t'(9)) r = {1'b1, bcd_t'(0)};
            else                r = {1'b0, bcd_t'(v + bcd_t'(1))};
        end else begin
            if (v == bcd_t'(0)) r = {1'b1, bcd_t'(9)};
            else                r = {1'b0, bcd_t'(v - bcd_t'(1))};
        end
        return r;
    endfunction

    function automatic bcd_t bcd_clamp(input bcd_t v);
        return (v > bcd_t'(9)) ? bcd_t'(9) : v;
    endfunction

endpackage

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
    parameter int DEBOUNCE_CYCLES = 1000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_i,
    output logic press_o
);
    localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          stable;
        logic [CW-1:0] cnt;
        logic          press;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = btn_i;
        st_d.sync2 = st_q.sync1;
        st_d.press = 1'b0;
        if (st_q.sync2 != st_q.stable) begin
            if (st_q.cnt == CW'(DEBOUNCE_CYCLES - 1)) begin
                st_d.stable = st_q.sync2;
                st_d.cnt    = '0;
                st_d.press  = st_q.sync2;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign press_o = st_q.press;

    // R6: a press is a single-cycle event
    p_single_press_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        press_o |=> !press_o);

    // R6: a press needs the filtered level to have been low before
    p_press_edge_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(press_o) |-> st_q.stable);

endmodule

// File: rtl/bcd_updown_core.sv
module bcd_updown_core
    import updn_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  load_i,
    input  logic [SW_W-1:0]       sw_i,
    input  logic                  press_i,
    input  logic                  tick_i,
    output logic [DIGITS-1:0][BCD_W-1:0] digits_o,
    output logic                  dir_up_o
);
    typedef struct packed {
        logic [DIGITS-1:0][BCD_W-1:0] val;
        logic                         dir_up;
    } core_t;

    core_t          st_d, st_q;
    logic           carry;
    logic [BCD_W:0] step_r;

    always_comb begin
        st_d  = st_q;
        carry = tick_i;
        step_r = '0;
        for (int i = 0; i < DIGITS; i++) begin
            step_r = bcd_step(st_q.val[i], st_q.dir_up);
            if (carry) st_d.val[i] = step_r[BCD_W-1:0];
            carry = carry & step_r[BCD_W];
        end
        if (press_i) st_d.dir_up = ~st_q.dir_up;
        if (load_i) begin
            for (int i = 0; i < DIGITS; i++)
                st_d.val[i] = bcd_clamp(sw_i[i*BCD_W +: BCD_W]);
            st_d.dir_up = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign digits_o = st_q.val;
    assign dir_up_o = st_q.dir_up;

    // R2: load restores up direction
    p_dir_load_r2: assert property (@(posedge clk_i)
        load_i |=> dir_up_o);

    // R3: no tick, no load, no change
    p_hold_r3: assert property (@(posedge clk_i) disable iff (load_i)
        (!tick_i && !$isunknown(st_q.val)) |=> $stable(digits_o));

    // R4: wrap at top
    p_wrap_up_r4: assert property (@(posedge clk_i) disable iff (load_i)
        (tick_i && dir_up_o && digits_o == {DIGITS{BCD_W'(9)}}) |=> digits_o == '0);

    // R5: wrap at bottom
    p_wrap_dn_r5: assert property (@(posedge clk_i) disable iff (load_i)
        (tick_i && !dir_up_o && digits_o == '0) |=> digits_o == {DIGITS{BCD_W'(9)}});

    // R8: digits stay in decimal range once loaded
    p_bcd_range_r8: assert property (@(posedge clk_i) disable iff (load_i)
        !$isunknown(st_q.val) |-> (digits_o[0] <= BCD_W'(9) && digits_o[DIGITS-1] <= BCD_W'(9)));

    // R9: direction only moves on a press or load
    p_dir_toggle_r9: assert property (@(posedge clk_i) disable iff (load_i)
        (!press_i && !$isunknown(st_q.dir_up)) |=> $stable(dir_up_o));

endmodule

// File: rtl/seg7_decoder.sv
module seg7_decoder
    import updn_pkg::*;
(
    input  logic [BCD_W-1:0] digit_i,
    output logic [SEG_W-1:0] seg_n_o
);
    logic [6:0] lit; // bit0 = a .. bit6 = g, 1 = lit

    always_comb begin
        unique case (digit_i)
            4'd0: lit = 7'b0111111;
            4'd1: lit = 7'b0000110;
            4'd2: lit = 7'b1011011;
            4'd3: lit = 7'b1001111;
            4'd4: lit = 7'b1100110;
            4'd5: lit = 7'b1101101;
            4'd6: lit = 7'b1111101;
            4'd7: lit = 7'b0000111;
            4'd8: lit = 7'b1111111;
            4'd9: lit = 7'b1101111;
            default: lit = 7'b0000000;
        endcase
    end

    assign seg_n_o = {1'b1, ~lit};

    // R7: decimal point is never lit
    always_comb begin
        p_dp_off_r7: assert (seg_n_o[SEG_W-1] == 1'b1);
    end

endmodule

// File: rtl/bcd_dial_counter.sv
module bcd_dial_counter
    import updn_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 1000
) (
    input  logic       clk_i,
    input  logic       load_i,
    input  logic [7:0] sw_i,
    input  logic       btn_i,
    input  logic       tick_i,
    output logic [3:0] ones_o,
    output logic [3:0] tens_o,
    output logic [7:0] seg_ones_n_o,
    output logic [7:0] seg_tens_n_o,
    output logic       dir_up_o
);
    logic                         press;
    logic [DIGITS-1:0][BCD_W-1:0] digits;
    logic [DIGITS-1:0][SEG_W-1:0] segs;

    btn_conditioner #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_btn (
        .clk_i   (clk_i),
        .rst_i   (load_i),
        .btn_i   (btn_i),
        .press_o (press)
    );

    bcd_updown_core u_core (
        .clk_i    (clk_i),
        .load_i   (load_i),
        .sw_i     (sw_i),
        .press_i  (press),
        .tick_i   (tick_i),
        .digits_o (digits),
        .dir_up_o (dir_up_o)
    );

    for (genvar g = 0; g < DIGITS; g++) begin : g_dec
        seg7_decoder u_dec (
            .digit_i (digits[g]),
            .seg_n_o (segs[g])
        );
    end

    assign ones_o       = digits[0];
    assign tens_o       = digits[1];
    assign seg_ones_n_o = segs[0];
    assign seg_tens_n_o = segs[1];

endmodule

// File: tb/bcd_dial_counter_bench.sv
module bcd_dial_counter_bench;
    localparam int DB = 8;

    logic       clk = 1'b0;
    logic       load = 1'b0;
    logic [7:0] sw = '0;
    logic       btn = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] ones, tens;
    logic [7:0] seg_o, seg_t;
    logic       dir;

    int errors = 0;
    int checks = 0;
    int exp_v  = 0;
    bit exp_d  = 1'b1;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bcd_dial_counter #(.DEBOUNCE_CYCLES(DB)) u_bcd_dial_counter (
        .clk_i(clk), .load_i(load), .sw_i(sw), .btn_i(btn), .tick_i(tick),
        .ones_o(ones), .tens_o(tens), .seg_ones_n_o(seg_o), .seg_tens_n_o(seg_t),
        .dir_up_o(dir)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cur();
        return int'(tens) * 10 + int'(ones);
    endfunction

    function automatic logic [7:0] seg_exp(input int d);
        logic [6:0] on;
        case (d)
            0: on = 7'h3F; 1: on = 7'h06; 2: on = 7'h5B; 3: on = 7'h4F;
            4: on = 7'h66; 5: on = 7'h6D; 6: on = 7'h7D; 7: on = 7'h07;
            8: on = 7'h7F; default: on = 7'h6F;
        endcase
        return {1'b1, ~on};
    endfunction

    task automatic do_load(input logic [7:0] v);
        @(negedge clk); load = 1'b1; sw = v;
        @(negedge clk); load = 1'b0;
        exp_v = ((v[7:4] > 9) ? 9 : int'(v[7:4])) * 10 + ((v[3:0] > 9) ? 9 : int'(v[3:0]));
        exp_d = 1'b1;
    endtask

    task automatic one_step();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        exp_v = exp_d ? (exp_v + 1) % 100 : (exp_v + 99) % 100;
    endtask

    task automatic press();
        @(negedge clk); btn = 1'b1;
        repeat (3*DB) @(negedge clk);
        btn = 1'b0;
        repeat (3*DB) @(negedge clk);
        exp_d = ~exp_d;
    endtask

    task automatic t_load();
        do_load(8'h47);
        check("R1 load 47", cur(), exp_v);
        check("R2 dir after load", int'(dir), 1);
        do_load(8'hAC);
        check("R1 clamp AC", cur(), 99);
        do_load(8'h3F);
        check("R1 clamp ones", cur(), 39);
    endtask

    task automatic t_priority();
        do_load(8'h10);
        press();
        check("R6 dir after press", int'(dir), 0);
        @(negedge clk); load = 1'b1; sw = 8'h55; tick = 1'b1;
        @(negedge clk); load = 1'b0; tick = 1'b0;
        check("R2 load beats tick", cur(), 55);
        check("R2 load sets up", int'(dir), 1);
        exp_v = 55; exp_d = 1'b1;
    endtask

    task automatic t_hold();
        do_load(8'h23);
        repeat (10) @(negedge clk);
        check("R3 hold without tick", cur(), 23);
    endtask

    task automatic t_up();
        do_load(8'h97);
        for (int k = 0; k < 5; k++) begin
            one_step();
            check("R4 up step", cur(), exp_v);
        end
        do_load(8'h19);
        one_step();
        check("R4 carry 19->20", cur(), 20);
    endtask

    task automatic t_down();
        do_load(8'h02);
        press();
        for (int k = 0; k < 5; k++) begin
            one_step();
            check("R5 down step", cur(), exp_v);
        end
        do_load(8'h30);
        press();
        one_step();
        check("R5 borrow 30->29", cur(), 29);
    endtask

    task automatic t_glitch();
        do_load(8'h00);
        @(negedge clk); btn = 1'b1;
        repeat (DB/2) @(negedge clk);
        btn = 1'b0;
        repeat (3*DB) @(negedge clk);
        check("R6 glitch ignored", int'(dir), 1);
        press();
        check("R6 one toggle", int'(dir), int'(exp_d));
        press();
        check("R6 second toggle", int'(dir), int'(exp_d));
    endtask

    task automatic t_same_cycle();
        int pv;
        bit pd;
        do_load(8'h50);
        @(negedge clk); tick = 1'b1; btn = 1'b1;
        for (int k = 0; k < 8*DB; k++) begin
            if (k == 4*DB) btn = 1'b0;
            pv = cur(); pd = dir;
            @(negedge clk);
            check("R9 step uses prior dir", cur(), pd ? (pv + 1) % 100 : (pv + 99) % 100);
            check("R8 digits in range", int'(ones <= 9 && tens <= 9), 1);
        end
        tick = 1'b0;
        check("R9 dir flipped once", int'(dir), 0);
    endtask

    task automatic t_segments();
        for (int d = 0; d < 10; d++) begin
            do_load({4'(d), 4'(9 - d)});
            check("R7 tens segments", int'(seg_t), int'(seg_exp(d)));
            check("R7 ones segments", int'(seg_o), int'(seg_exp(9 - d)));
        end
    endtask

    initial begin
        load = 1'b1;
        repeat (3) @(negedge clk);
        load = 1'b0;
        check("R1 reset state", cur(), 0);
        check("R2 reset dir", int'(dir), 1);
        t_load();
        t_priority();
        t_hold();
        t_up();
        t_down();
        t_glitch();
        t_same_cycle();
        t_segments();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule